// File: doc/BRIEF.md
# Multicycle Floating-Point Issue Interlock

This block sits in the decode stage of an in-order pipeline that has one integer execution path and three floating-point paths of different lengths: a pipelined adder, a pipelined multiplier and a divider that is not pipelined. Each cycle, decode presents at most one decoded instruction. The instruction carries a unit code, two source register numbers, a destination register number and a write-enable. The interlock decides in the same cycle whether the instruction may leave decode. If it may not, the interlock raises a stall, and decode holds the instruction unchanged until it issues.

Three kinds of state drive the decision. The first is a register scoreboard of cycles remaining until each pending result can be forwarded. The second is a map of write-back cycles that are already claimed, one bit per future cycle. The third is an occupancy counter for the divider. From these the block detects read-after-write hazards, write-after-write hazards, collisions on the single write-back port and divider busy conflicts. For each source operand it also reports whether that operand is ready to forward. Write-after-read hazards need no check, because operands are read in order when the instruction issues.

Top module: `fp_issue_interlock`

## Requirements
- R1: At most one instruction issues per cycle, in program order. `issue` is high exactly when `in_valid` is high and `stall` is low. `stall` is never high without `in_valid`. `issue_unit` carries the unit code of the issued instruction. Unit codes are 0 integer, 1 FP add, 2 multiply, 3 divide.
- R2: An instruction issued in cycle t writes back in cycle t+L. L is 1 for integer, 4 for add, 7 for multiply and 25 for divide. Its result latency is L-1 cycles, which gives 0, 3, 6 and 24.
- R3: An instruction that reads a register with a pending result stalls until L-1 cycles have passed between the producer's issue cycle and its own issue cycle. `src_a_ready` and `src_b_ready` are low while their register still has a result pending, whether or not `in_valid` is high.
- R4: A divide cannot issue within 25 cycles of the previous divide. Two back-to-back divides therefore cost the second one exactly 24 stall cycles.
- R5: No two instructions may claim the same write-back cycle. A candidate whose write-back cycle t+L is already claimed stalls.
- R6: A candidate that writes a register stalls while an earlier in-flight writer of the same register would write back in the same cycle as the candidate or later.
- R7: An instruction with `in_dst_we` low creates no pending result and is not checked for write-after-write hazards.
- R8: Synchronous active-low reset clears all pending results, all write-back claims and the divider occupancy. After reset, every source reads ready and a divide may issue at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Decode holds an instruction |
| in_unit | input | 2 | Unit code: 0 int, 1 add, 2 mul, 3 div |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| in_dst | input | 5 | Destination register |
| in_dst_we | input | 1 | Instruction writes `in_dst` |
| stall | output | 1 | Hold the instruction in decode |
| issue | output | 1 | Instruction leaves decode this cycle |
| issue_unit | output | 2 | Unit of the issued instruction, 0 when idle |
| src_a_ready | output | 1 | First source has no pending result |
| src_b_ready | output | 1 | Second source has no pending result |

## Verification
The assertions assume that decode holds a stalled instruction unchanged until it issues, that every unit code is one of the four defined, and that reset is applied before the first instruction. The divider-spacing and write-back-uniqueness checks count from the cycle of an observed issue, so the only thing they rely on is that `issue` marks the instruction actually consumed. The stimulus keeps to these assumptions in several ways. Its issue task repeats the same instruction every cycle until the block accepts it. It draws unit codes only from the four legal values. It begins with reset, and it asserts reset again in the middle of the run while a divide is busy. Register numbers are drawn from a small set so that read-after-write, write-after-write and write-back collisions occur often.

// File: rtl/fpil_pkg.sv
// Package: fpil_pkg
// Shared unit codes and default path lengths for the issue interlock.
// Assumes the divider has the longest path of all units.
package fpil_pkg;

    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_ADD = 2'd1,
        UNIT_MUL = 2'd2,
        UNIT_DIV = 2'd3
    } unit_e;

    localparam int DEF_NUM_REGS   = 32;
    localparam int DEF_INT_STAGES = 1;
    localparam int DEF_ADD_STAGES = 4;
    localparam int DEF_MUL_STAGES = 7;
    localparam int DEF_DIV_STAGES = 25;
    localparam int DEF_DIV_II     = 25;

endpackage

// File: rtl/fpil_wb_reserve.sv
// Module: fpil_wb_reserve
// Write-back claim map. While a cycle is running, bit j means that the
// cycle j cycles ahead already has a write-back. The map shifts down one
// bit every cycle. The candidate checks bit LEN. On a claim the map sets
// LEN-1, because that bit names the same cycle once the map has shifted.
// Assumes chk_len is at least 1.
module fpil_wb_reserve #(
    parameter int RES_W = 26,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] chk_len,
    input  logic             claim,
    output logic             slot_busy
);

    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] claim_bit;

    // Look up the candidate's write-back cycle.
    assign slot_busy = res_q[chk_len];

    // One-hot bit to set for a claim, already shifted by one.
    assign claim_bit = claim ? (RES_W'(1) << (chk_len - LEN_W'(1))) : '0;

    // Advance the map by one cycle and record a new claim.
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= (res_q >> 1) | claim_bit;
    end

endmodule

// File: rtl/fpil_pend_table.sv
// Module: fpil_pend_table
// Per-register scoreboard. Each entry holds the number of cycles left
// before its result can be forwarded. An entry is loaded when a writer
// issues and counts down to zero. Entries are read for both sources and
// for the destination.
module fpil_pend_table #(
    parameter int NREGS = 32,
    parameter int REG_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] dst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b,
    output logic [CNT_W-1:0] cnt_dst
);

    logic [CNT_W-1:0] cnt_q [NREGS];

    for (genvar r = 0; r < NREGS; r++) begin : g_entry
        // Load on a matching issue, otherwise count toward zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                            cnt_q[r] <= '0;
            else if (load && dst == REG_W'(r))     cnt_q[r] <= load_val;
            else if (cnt_q[r] != '0)               cnt_q[r] <= cnt_q[r] - CNT_W'(1);
        end
    end

    // Read ports for the hazard checks.
    assign cnt_a   = cnt_q[src_a];
    assign cnt_b   = cnt_q[src_b];
    assign cnt_dst = cnt_q[dst];

endmodule

// File: rtl/fpil_div_occ.sv
// Module: fpil_div_occ
// Occupancy of the divider, which is not pipelined. The unit reads busy
// for II-1 cycles after a start, so the next start comes II cycles later.
module fpil_div_occ #(
    parameter int II = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int OCC_W = $clog2(II);

    logic [OCC_W-1:0] occ_q;

    // Load the repeat interval on a start and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)            occ_q <= '0;
        else if (start)        occ_q <= OCC_W'(II - 1);
        else if (occ_q != '0)  occ_q <= occ_q - OCC_W'(1);
    end

    assign busy = (occ_q != '0);

endmodule

// File: rtl/fp_issue_interlock.sv
// Module: fp_issue_interlock
// Decode-stage issue control for an in-order pipeline with integer, add,
// multiply and divide paths. It stalls the instruction in decode on a
// read-after-write, write-after-write, write-back collision or divider busy
// hazard. Otherwise it issues the instruction at once. Outputs are
// combinational from this cycle's inputs and registered state.
// Assumes: decode holds a stalled instruction unchanged, the divide path
// is the longest, and every path is at least one stage long.
module fp_issue_interlock
    import fpil_pkg::*;
#(
    parameter int NUM_REGS   = DEF_NUM_REGS,
    parameter int INT_STAGES = DEF_INT_STAGES,
    parameter int ADD_STAGES = DEF_ADD_STAGES,
    parameter int MUL_STAGES = DEF_MUL_STAGES,
    parameter int DIV_STAGES = DEF_DIV_STAGES,
    parameter int DIV_II     = DEF_DIV_II
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] in_unit,
    input  logic [4:0] in_src_a,
    input  logic [4:0] in_src_b,
    input  logic [4:0] in_dst,
    input  logic       in_dst_we,
    output logic       stall,
    output logic       issue,
    output logic [1:0] issue_unit,
    output logic       src_a_ready,
    output logic       src_b_ready
);

    localparam int REG_W = $clog2(NUM_REGS);
    localparam int LEN_W = $clog2(DIV_STAGES + 1);
    localparam int RES_W = DIV_STAGES + 1;

    logic [LEN_W-1:0] path_len;
    logic [LEN_W-1:0] cnt_a, cnt_b, cnt_dst;
    logic             slot_busy, div_busy;
    logic             raw_hz, waw_hz, div_hz;

    // Write-back distance of the candidate's unit.
    always_comb begin
        unique case (unit_e'(in_unit))
            UNIT_INT: path_len = LEN_W'(INT_STAGES);
            UNIT_ADD: path_len = LEN_W'(ADD_STAGES);
            UNIT_MUL: path_len = LEN_W'(MUL_STAGES);
            default:  path_len = LEN_W'(DIV_STAGES);
        endcase
    end

    fpil_pend_table #(
        .NREGS (NUM_REGS),
        .REG_W (REG_W),
        .CNT_W (LEN_W)
    ) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_a    (in_src_a[REG_W-1:0]),
        .src_b    (in_src_b[REG_W-1:0]),
        .dst      (in_dst[REG_W-1:0]),
        .load     (issue && in_dst_we),
        .load_val (path_len - LEN_W'(1)),
        .cnt_a    (cnt_a),
        .cnt_b    (cnt_b),
        .cnt_dst  (cnt_dst)
    );

    fpil_wb_reserve #(
        .RES_W (RES_W),
        .LEN_W (LEN_W)
    ) wbres_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_len   (path_len),
        .claim     (issue),
        .slot_busy (slot_busy)
    );

    fpil_div_occ #(
        .II (DIV_II)
    ) divocc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue && unit_e'(in_unit) == UNIT_DIV),
        .busy  (div_busy)
    );

    // Hazard terms. A pending writer stalls the candidate when its remaining count is at least the candidate's path length.
    assign raw_hz = (cnt_a != '0) || (cnt_b != '0);
    assign waw_hz = in_dst_we && (cnt_dst >= path_len);
    assign div_hz = (unit_e'(in_unit) == UNIT_DIV) && div_busy;

    // Issue decision and outputs.
    assign stall       = in_valid && (raw_hz || waw_hz || slot_busy || div_hz);
    assign issue       = in_valid && !stall;
    assign issue_unit  = issue ? in_unit : 2'd0;
    assign src_a_ready = (cnt_a == '0);
    assign src_b_ready = (cnt_b == '0);

endmodule

// File: rtl/fpil_checker.sv
// Module: fpil_checker
// Property checks for fp_issue_interlock, bound to every instance. It keeps
// its own divide spacing counter and its own record of claimed write-back
// cycles, both built from the observed issue stream.
module fpil_checker #(
    parameter int INT_STAGES = 1,
    parameter int ADD_STAGES = 4,
    parameter int MUL_STAGES = 7,
    parameter int DIV_STAGES = 25,
    parameter int DIV_II     = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] in_unit,
    input logic       issue,
    input logic       src_a_ready,
    input logic       src_b_ready
);

    localparam int GAP_W = $clog2(DIV_II + 1);
    localparam int LEN_W = $clog2(DIV_STAGES + 1);
    localparam int MAP_W = DIV_STAGES + 1;

    logic [GAP_W-1:0] gap_q;
    logic [MAP_W-1:0] seen_q;
    logic [LEN_W-1:0] len;

    // Unit path length taken from the parameters.
    always_comb begin
        case (in_unit)
            2'd0:    len = LEN_W'(INT_STAGES);
            2'd1:    len = LEN_W'(ADD_STAGES);
            2'd2:    len = LEN_W'(MUL_STAGES);
            default: len = LEN_W'(DIV_STAGES);
        endcase
    end

    // Cycles since the last divide issue, saturating at the interval.
    always_ff @(posedge clk) begin
        if (!rst_n)                         gap_q <= GAP_W'(DIV_II);
        else if (issue && in_unit == 2'd3)  gap_q <= GAP_W'(1);
        else if (gap_q < GAP_W'(DIV_II))    gap_q <= gap_q + GAP_W'(1);
    end

    // Write-back cycles already taken by issued instructions.
    always_ff @(posedge clk) begin
        if (!rst_n)     seen_q <= '0;
        else if (issue) seen_q <= (seen_q >> 1) | (MAP_W'(1) << (len - LEN_W'(1)));
        else            seen_q <= seen_q >> 1;
    end

    a_r4_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_unit == 2'd3) |-> (gap_q >= GAP_W'(DIV_II)));

    a_r5_single_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !seen_q[len]);

    a_r3_sources_ready: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (src_a_ready && src_b_ready));

    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (src_a_ready && src_b_ready));

endmodule

bind fp_issue_interlock fpil_checker #(
    .INT_STAGES (INT_STAGES),
    .ADD_STAGES (ADD_STAGES),
    .MUL_STAGES (MUL_STAGES),
    .DIV_STAGES (DIV_STAGES),
    .DIV_II     (DIV_II)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_unit     (in_unit),
    .issue       (issue),
    .src_a_ready (src_a_ready),
    .src_b_ready (src_b_ready)
);

// File: tb/fp_issue_interlock_tb_top.sv
// Bench: fp_issue_interlock_tb_top
// Reference model in absolute cycle numbers: the cycle from which each
// register is ready, the write-back cycle of each register's last writer,
// a ring of claimed write-back cycles, and the cycle of the last divide.
module fp_issue_interlock_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_unit = 2'd0;
    logic [4:0] in_src_a = 5'd0, in_src_b = 5'd0, in_dst = 5'd0;
    logic       in_dst_we = 1'b0;
    logic       stall, issue, src_a_ready, src_b_ready;
    logic [1:0] issue_unit;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    int rdy_t [32];
    int wb_t  [32];
    bit slot  [64];
    int last_div;
    int cyc;

    always #10 clk = ~clk;

    fp_issue_interlock dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_unit (in_unit),
        .in_src_a (in_src_a), .in_src_b (in_src_b), .in_dst (in_dst),
        .in_dst_we (in_dst_we), .stall (stall), .issue (issue),
        .issue_unit (issue_unit), .src_a_ready (src_a_ready),
        .src_b_ready (src_b_ready)
    );

    function automatic int plen(input logic [1:0] u);
        case (u)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 7;
            default: return 25;
        endcase
    endfunction

    function automatic bit exp_stall();
        int l;
        bit s;
        l = plen(in_unit);
        s = 0;
        if (rdy_t[in_src_a] > cyc || rdy_t[in_src_b] > cyc) s = 1;          // R3
        if (in_dst_we && wb_t[in_dst] >= cyc + l) s = 1;                    // R6, R7
        if (slot[(cyc + l) % 64]) s = 1;                                     // R5
        if (in_unit == 2'd3 && cyc < last_div + 25) s = 1;                   // R4
        return in_valid && s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < 32; r++) begin rdy_t[r] = 0; wb_t[r] = 0; end
        for (int k = 0; k < 64; k++) slot[k] = 0;
        last_div = -100;
        cyc = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
    endtask

    // One cycle: compare at the falling edge, then advance the model.
    task automatic run_cycle(output bit issued);
        bit es;
        @(negedge clk);
        es = exp_stall();
        issued = in_valid && !es;
        check(stall == es, "R1 stall", int'(stall), int'(es));
        check(issue == issued, "R1 issue", int'(issue), int'(issued));
        if (issued) check(issue_unit == in_unit, "R1 issue_unit", int'(issue_unit), int'(in_unit));
        check(src_a_ready == (rdy_t[in_src_a] <= cyc), "R3 src_a_ready",
              int'(src_a_ready), int'(rdy_t[in_src_a] <= cyc));
        check(src_b_ready == (rdy_t[in_src_b] <= cyc), "R3 src_b_ready",
              int'(src_b_ready), int'(rdy_t[in_src_b] <= cyc));
        @(posedge clk);
        if (issued) begin
            int l;
            l = plen(in_unit);                                                // R2
            if (in_dst_we) begin
                rdy_t[in_dst] = cyc + l;
                wb_t[in_dst]  = cyc + l;
            end
            slot[(cyc + l) % 64] = 1;
            if (in_unit == 2'd3) last_div = cyc;
        end
        slot[cyc % 64] = 0;
        cyc++;
        #1;
    endtask

    task automatic issue_instr(input logic [1:0] u, input int a, input int b,
                               input int d, input bit we, output int stalls);
        bit issued;
        stalls = 0;
        in_valid = 1'b1;
        in_unit = u;
        in_src_a = 5'(a);
        in_src_b = 5'(b);
        in_dst = 5'(d);
        in_dst_we = we;
        issued = 0;
        while (!issued && stalls < 60) begin
            run_cycle(issued);
            if (!issued) stalls++;
        end
        if (!issued) check(0, "R1 hung issue", stalls, 0);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        bit issued;
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) run_cycle(issued);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int s;
        void'($urandom(32'd20240611));
        do_reset();

        // R8: state after reset.
        in_src_a = 5'd3; in_src_b = 5'd9;
        @(negedge clk);
        check(stall == 1'b0, "R8 stall after reset", int'(stall), 0);
        check(src_a_ready && src_b_ready, "R8 sources ready", int'(src_a_ready && src_b_ready), 1);
        @(posedge clk); #1;
        do_reset();

        // R3 chain: integer load, multiply, add, integer store.
        issue_instr(2'd0, 2, 2, 4, 1, s);  check(s == 0, "R3 load stalls", s, 0);
        issue_instr(2'd2, 4, 6, 0, 1, s);  check(s == 0, "R3 mul after load", s, 0);
        issue_instr(2'd1, 0, 8, 2, 1, s);  check(s == 6, "R3 add after mul", s, 6);
        issue_instr(2'd0, 2, 10, 0, 0, s); check(s == 3, "R3 store after add", s, 3);
        idle(30);

        // R4: back-to-back divides.
        issue_instr(2'd3, 1, 3, 20, 1, s); check(s == 0, "R4 first div", s, 0);
        issue_instr(2'd3, 5, 7, 21, 1, s); check(s == 24, "R4 second div", s, 24);
        idle(30);

        // R6: integer write to a register a multiply still owes.
        issue_instr(2'd2, 1, 1, 5, 1, s);  check(s == 0, "R6 mul", s, 0);
        issue_instr(2'd0, 2, 3, 5, 1, s);  check(s == 6, "R6 waw stall", s, 6);
        idle(10);

        // R5: add whose write-back lands on the multiply's write-back cycle.
        issue_instr(2'd2, 1, 1, 11, 1, s);
        issue_instr(2'd0, 1, 1, 14, 1, s);
        issue_instr(2'd0, 1, 1, 15, 1, s);
        issue_instr(2'd1, 1, 1, 12, 1, s); check(s == 1, "R5 wb collision", s, 1);
        idle(10);

        // R7: no write-enable means no pending result.
        issue_instr(2'd1, 1, 1, 13, 0, s);
        issue_instr(2'd0, 13, 13, 16, 1, s); check(s == 0, "R7 no pending", s, 0);
        idle(10);

        // R8: reset while the divider is busy.
        issue_instr(2'd3, 1, 1, 20, 1, s);
        idle(3);
        do_reset();
        issue_instr(2'd3, 20, 20, 22, 1, s); check(s == 0, "R8 div after reset", s, 0);
        idle(30);

        // Random mix over a small register set.
        for (int i = 0; i < 1500; i++) begin
            int r;
            logic [1:0] u;
            r = int'($urandom % 16);
            u = (r < 7) ? 2'd0 : (r < 11) ? 2'd1 : (r < 14) ? 2'd2 : 2'd3;
            if ($urandom % 5 == 0) idle(1);
            issue_instr(u, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                        ($urandom % 4) != 0, s);
        end
        idle(30);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule